// File: doc/BRIEF.md
# Bidirectional Warm Reset Sequencer

This block runs the warm reset sequence for one shared, open-drain, active-low reset line. Other devices may pull the line low, and the block may pull it low itself. The block runs on the oscillator clock. It watches the synchronized line level. When the line falls from high to low, the block raises its internal reset and pulls the line low on its own. It holds the line for a fixed base count plus a programmable first interval. It then lets go of the line and waits for the line to read high. After that it counts a programmable second interval and only then drops the internal reset. A source that keeps the line low after the block lets go holds the sequence at that point. The second count begins only when the line comes back high.

The sequencer has four states. IDLE waits for a falling edge. The transition *trigger* (IDLE to DRIVE) latches both interval fields and loads the drive counter. DRIVE pulls the line low until the counter expires. The transition *let-go* (DRIVE to HOLD) stops the drive. HOLD waits while the synchronized line reads low. It then takes the transition *line-high*: to PHASE2 when the second field is non-zero, or straight to IDLE when the field is zero. PHASE2 counts the second interval. Its transition *release* (PHASE2 to IDLE) drops the internal reset. The short first interval gives no useful debounce for a mechanical switch.

Top module: `warm_reset_seq`

## Requirements
- R1: After cold reset (`rst_n` low), the block is in IDLE with `pin_drive_low`, `core_reset` and `busy` all 0.
- R2: A sequence starts only on a high-to-low change of the line, seen through a two-flop synchronizer. If the line is first low before clock edge k, then `busy`, `core_reset` and `pin_drive_low` are 1 after edge k+2. A line held low from cold reset onward does not start a sequence, and neither does a low-to-high change.
- R3: `pin_drive_low` stays 1 for exactly BASE_CYCLES (default 40) plus `phase1_len` cycles. `phase1_len` is an unsigned 8-bit count and is latched at the trigger.
- R4: With no other source holding the line, `busy` stays 1 for exactly BASE_CYCLES + `phase1_len` + 3 + `phase2_len` cycles. The 3 covers the let-go cycle and the two synchronizer stages. `phase2_len` is an unsigned 8-bit count, latched at the trigger. A value of 0 releases the reset as soon as the line reads high.
- R5: While another source holds the line low after let-go, the second count does not advance. Suppose the external low starts before edge k and ends before edge k+H. Then `busy` stays 1 for max(H, BASE_CYCLES + `phase1_len` + 3) + `phase2_len` cycles.
- R6: A falling edge of the line during DRIVE, HOLD or PHASE2 is ignored. It neither lengthens the sequence nor starts a new one after release.
- R7: A falling edge after the internal reset has been released starts a fresh sequence with the same timing.
- R8: `core_reset` and `busy` are 1 over exactly the same cycles, from trigger to release. `pin_drive_low` is 1 only while `busy` is 1, and it rises in the same cycle as `busy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Cold reset, active low, asynchronous |
| pin_in | input | 1 | Raw level sampled from the shared reset line (1 = high) |
| phase1_len | input | 8 | Extra drive cycles added to the base count |
| phase2_len | input | 8 | Cycles counted after the line reads high, before release |
| pin_drive_low | output | 1 | 1 = pull the shared line low |
| core_reset | output | 1 | Internal warm reset, active high |
| busy | output | 1 | 1 from trigger until internal reset release |

## Verification
The bench models the shared line as the wired-AND of an external source and the block's own drive. It sweeps both interval fields across zero, one, small and full-scale values using a one-cycle external pulse. This separates errors in the base count, the first field, the synchronizer latency and the second field. External holds that end before, exactly at and after the point where the line would have risen on its own show whether the second count pauses correctly. Further runs check a low level present from cold reset, a glitch during the second interval, and back-to-back sequences. These separate edge detection from level detection and show whether edges are ignored while the block is busy.

// File: rtl/wrs_pkg.sv
package wrs_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_DRIVE  = 2'd1,
        ST_HOLD   = 2'd2,
        ST_PHASE2 = 2'd3
    } wrs_state_t;
endpackage

// File: rtl/wrs_sync.sv
module wrs_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[0] <= 1'b0;
                    else        chain[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[i] <= 1'b0;
                    else        chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/wrs_fall_detect.sv
module wrs_fall_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    output logic fall
);
    logic prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev <= 1'b0;
        else        prev <= level;
    end

    assign fall = prev & ~level;

    // R2: a reported fall always follows a high level one cycle earlier
    p_fall_after_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
        fall |-> $past(level));
endmodule

// File: rtl/wrs_counter.sv
module wrs_counter #(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic [W-1:0] cnt,
    output logic         zero
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     cnt <= '0;
        else if (load)  cnt <= load_val;
        else if (dec)   cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);

    // R3: decrement never wraps below zero
    p_no_underflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && !load) |-> !zero);
endmodule

// File: rtl/warm_reset_seq.sv
module warm_reset_seq #(
    parameter int BASE_CYCLES = 40,
    parameter int FIELD_W     = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pin_in,
    input  logic [FIELD_W-1:0] phase1_len,
    input  logic [FIELD_W-1:0] phase2_len,
    output logic               pin_drive_low,
    output logic               core_reset,
    output logic               busy
);
    import wrs_pkg::*;

    localparam int CNT_W = $clog2(BASE_CYCLES + (1 << FIELD_W));

    wrs_state_t         state_q, state_d;
    logic               pin_s;
    logic               fall;
    logic [FIELD_W-1:0] p2_q;
    logic               cnt_load;
    logic               cnt_dec;
    logic [CNT_W-1:0]   cnt_val;
    logic [CNT_W-1:0]   cnt;
    logic               cnt_zero;

    wrs_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pin_in),
        .q     (pin_s)
    );

    wrs_fall_detect u_fall (
        .clk   (clk),
        .rst_n (rst_n),
        .level (pin_s),
        .fall  (fall)
    );

    wrs_counter #(.W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cnt_load),
        .load_val (cnt_val),
        .dec      (cnt_dec),
        .cnt      (cnt),
        .zero     (cnt_zero)
    );

    // next-state and counter control
    always_comb begin
        state_d  = state_q;
        cnt_load = 1'b0;
        cnt_dec  = 1'b0;
        cnt_val  = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (fall) begin
                    state_d  = ST_DRIVE;
                    cnt_load = 1'b1;
                    cnt_val  = CNT_W'(BASE_CYCLES - 1) + CNT_W'(phase1_len);
                end
            end
            ST_DRIVE: begin
                if (cnt_zero) state_d = ST_HOLD;
                else          cnt_dec = 1'b1;
            end
            ST_HOLD: begin
                if (pin_s) begin
                    if (p2_q == '0) begin
                        state_d = ST_IDLE;
                    end else begin
                        state_d  = ST_PHASE2;
                        cnt_load = 1'b1;
                        cnt_val  = CNT_W'(p2_q) - 1'b1;
                    end
                end
            end
            ST_PHASE2: begin
                if (cnt_zero) state_d = ST_IDLE;
                else          cnt_dec = 1'b1;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register and trigger-time latch
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            p2_q    <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && fall) p2_q <= phase2_len;
        end
    end

    // outputs decoded from state
    always_comb begin
        pin_drive_low = 1'b0;
        busy          = 1'b1;
        unique case (state_q)
            ST_IDLE:   busy = 1'b0;
            ST_DRIVE:  pin_drive_low = 1'b1;
            ST_HOLD:   pin_drive_low = 1'b0;
            ST_PHASE2: pin_drive_low = 1'b0;
            default:   busy = 1'b0;
        endcase
        core_reset = busy;
    end

    // R2: a synchronized falling edge in IDLE starts the drive phase
    p_start_on_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && fall) |=> (state_q == ST_DRIVE));
    // R2: without an edge, IDLE is kept
    p_stay_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !fall) |=> (state_q == ST_IDLE));
    // R3: drive counter steps down by one each cycle until it expires
    p_drive_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DRIVE && !cnt_zero) |=> (state_q == ST_DRIVE && cnt == $past(cnt) - 1'b1));
    // R5: second phase is held off while the line reads low
    p_hold_pause_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD && !pin_s) |=> (state_q == ST_HOLD));
    // R6: an edge during the second phase does not cut or extend it
    p_phase2_runs_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PHASE2 && !cnt_zero) |=> (state_q == ST_PHASE2));
    // R8: drive ends only by passing into HOLD
    p_drive_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pin_drive_low) |-> (state_q == ST_HOLD));
endmodule

// File: tb/warm_reset_seq_test.sv
module warm_reset_seq_test;
    localparam int BASE = 40;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ext_low = 1'b0;
    logic [7:0] p1 = 8'd0;
    logic [7:0] p2 = 8'd0;
    logic       pin_drive_low, core_reset, busy;
    logic       pin;

    int tests = 0;
    int fails = 0;
    int cycles = 0;

    assign pin = ~(pin_drive_low | ext_low);

    always #10 clk = ~clk;

    warm_reset_seq uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .pin_in        (pin),
        .phase1_len    (p1),
        .phase2_len    (p2),
        .pin_drive_low (pin_drive_low),
        .core_reset    (core_reset),
        .busy          (busy)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // one sequence: external low starts at sample 0, ends at sample h
    task automatic run_seq(input int a1, input int a2, input int h, input int pulse_at);
        int n, exp_busy, first, nbusy, ndrive, dfirst, mism, bad_drive;
        bit seen;
        n = BASE + a1;
        exp_busy = ((h > n + 3) ? h : n + 3) + a2;
        first = -1; dfirst = -1; nbusy = 0; ndrive = 0; mism = 0; bad_drive = 0; seen = 0;
        p1 = 8'(a1);
        p2 = 8'(a2);
        @(negedge clk);
        ext_low = 1'b1;
        for (int i = 1; i < 1200; i++) begin
            @(negedge clk);
            if (i == h) ext_low = 1'b0;
            if (pulse_at != 0 && i == pulse_at) ext_low = 1'b1;
            if (pulse_at != 0 && i == pulse_at + 3) ext_low = 1'b0;
            if (core_reset != busy) mism++;
            if (pin_drive_low && !busy) bad_drive++;
            if (pin_drive_low) begin
                ndrive++;
                if (dfirst < 0) dfirst = i;
            end
            if (busy) begin
                nbusy++;
                seen = 1;
                if (first < 0) first = i;
            end else if (seen && i > h + 5) begin
                break;
            end
        end
        chk(first == 3, "R2 trigger latency", first, 3);
        chk(ndrive == n, "R3 drive length", ndrive, n);
        if (h > n + 3) chk(nbusy == exp_busy, "R5 busy length with external hold", nbusy, exp_busy);
        else           chk(nbusy == exp_busy, "R4 busy length with free line", nbusy, exp_busy);
        chk(mism == 0 && bad_drive == 0 && dfirst == first, "R8 busy/core_reset/drive alignment",
            mism + bad_drive, 0);
    endtask

    task automatic expect_idle(input int ncyc, input string req);
        int hits;
        hits = 0;
        for (int i = 0; i < ncyc; i++) begin
            @(negedge clk);
            if (busy || core_reset || pin_drive_low) hits++;
        end
        chk(hits == 0, req, hits, 0);
    endtask

    initial begin
        int p1s[4] = '{0, 1, 5, 255};
        int p2s[4] = '{0, 1, 7, 255};
        // R2: line held low from cold reset on must not start a sequence
        ext_low = 1'b1;
        repeat (3) @(negedge clk);
        chk(!busy && !core_reset && !pin_drive_low, "R1 reset state", busy, 0);
        rst_n = 1'b1;
        expect_idle(20, "R2 steady low after reset ignored");
        ext_low = 1'b0;
        expect_idle(10, "R2 rising edge ignored");

        // R4/R3 sweep with one-cycle external pulse
        foreach (p1s[a]) begin
            foreach (p2s[b]) begin
                run_seq(p1s[a], p2s[b], 1, 0);
                expect_idle(4, "R7 idle between sequences");
            end
        end

        // R5 external hold beyond, at and just past the free rise point
        run_seq(0, 7, 60, 0);
        run_seq(0, 7, 43, 0);
        run_seq(0, 0, 44, 0);
        run_seq(255, 3, 300, 0);
        run_seq(5, 1, 120, 0);

        // R6: glitch during second phase ignored
        run_seq(0, 100, 1, 60);
        expect_idle(30, "R6 no retrigger after ignored edge");
        // R6: glitch during drive ignored
        run_seq(10, 5, 1, 20);
        expect_idle(30, "R6 no retrigger after drive-phase edge");

        // R7: fresh sequence right after release
        run_seq(2, 2, 1, 0);
        run_seq(2, 2, 1, 0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule